// File: doc/BRIEF.md
# Serial ADC Output Port Model

This block is a synthesizable digital stand-in for the control and serial read-out side of a sampling converter. It can serve as a device under test or as an emulator for host logic that drives a converter. A parallel input carries the 14-bit word that the analog core would have produced. A convert strobe starts each conversion, a busy flag covers the conversion time, and the result is shifted out as a 16-bit frame on a serial clock through a data line that can float.

The model is faithful to the port's misuse cases. After sixteen serial clock pulses the shift position returns to its idle state and the line floats. Further pulses do not hold the line in that state; they step the position round again. Every falling strobe edge forces the position back to idle, so a read that crosses a strobe edge comes back misaligned.

In fast mode the falling strobe edge both starts the conversion and takes the sample. In power-saving mode the rising strobe edge wakes the part. The sample is taken a fixed wake time later, and conversion follows. The strobe and the serial clock are sampled on the system clock, and both times are parameters counted in system clock cycles. An observation flag goes high once the output register holds a completed result.

Top module: `serial_adc_port_model`

## Requirements
- R1: In fast mode (`shutdown_mode`=0), a falling edge on `conv_n` while idle sets `busy` on the next clock, captures `sample_in` on that same clock, and clears `data_valid`.
- R2: `busy` stays high for exactly CONV_CYCLES clocks after a fast-mode start. On the clock where it falls, the captured sample moves to the output register and `data_valid` goes high.
- R3: A frame is 16 bits, sent MSB first: two zero bits, then the 14-bit sample MSB first. Each falling edge of `sclk` presents the next bit, and the first falling edge presents frame bit 15.
- R4: On the rising `sclk` edge that ends the 16th pulse, the position returns to idle and `sdata_oe` goes low.
- R5: Pulses after the 16th step the position forward again from idle. Pulse 16+k presents frame bit 16-k with `sdata_oe` high.
- R6: Every falling edge of `conv_n` returns the position to idle, whether or not a read or a conversion is under way. A read that crosses such an edge continues from frame bit 15 of the register's contents at that point.
- R7: Strobe edges that arrive while `busy` is high neither restart nor lengthen the conversion, and they do not replace the captured sample.
- R8: In power-saving mode (`shutdown_mode`=1), a falling `conv_n` edge starts nothing. A rising edge sets `busy`, `sample_in` is captured WAKE_CYCLES clocks later, and `busy` stays high for WAKE_CYCLES+CONV_CYCLES clocks in total.
- R9: After reset, `busy`, `sdata_oe`, `sdata` and `data_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shutdown_mode | input | 1 | 0: fast mode, 1: power-saving mode |
| conv_n | input | 1 | Convert strobe (idles high) |
| sclk | input | 1 | Serial clock (idles high), synchronous to clk and slower than it |
| sample_in | input | 14 | Word standing in for the analog core output |
| busy | output | 1 | Conversion in progress |
| sdata | output | 1 | Serial data; low when not driven |
| sdata_oe | output | 1 | High while the data line is driven |
| data_valid | output | 1 | Output register holds the last completed result |

## Verification
The assertions assume that `conv_n` and `sclk` change only between system clock edges, that each level lasts at least one clock, and that `shutdown_mode` changes only while the block is idle. The stimulus drives every input on the falling system clock edge, keeps each serial clock phase one clock long, and changes mode only after `busy` has fallen. Sample values sweep walking ones, all zeros, all ones and alternating patterns. Strobe edges are deliberately placed inside conversions and inside reads to reach the misuse paths.

// File: rtl/serial_adc_port_model.sv
module serial_adc_port_model #(
  parameter int SAMPLE_W    = 14,
  parameter int FRAME_W     = 16,
  parameter int CONV_CYCLES = 500,
  parameter int WAKE_CYCLES = 500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shutdown_mode,
  input  logic                conv_n,
  input  logic                sclk,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                busy,
  output logic                sdata,
  output logic                sdata_oe,
  output logic                data_valid
);
  localparam int LEAD_W  = FRAME_W - SAMPLE_W;
  localparam int CNT_MAX = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int POS_W   = $clog2(FRAME_W + 1);
  localparam int IDX_W   = $clog2(FRAME_W);

  logic                conv_q, sclk_q, waking;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] held, result;
  logic [POS_W-1:0]    pos;
  logic [FRAME_W-1:0]  frame;
  logic [IDX_W-1:0]    bit_idx;

  wire conv_fall = conv_q & ~conv_n;
  wire conv_rise = ~conv_q & conv_n;
  wire sclk_fall = sclk_q & ~sclk;
  wire sclk_rise = ~sclk_q & sclk;
  wire start_evt = ~busy & (shutdown_mode ? conv_rise : conv_fall);
  wire cnt_last  = (cnt == '0);
  wire pos_end   = (pos == POS_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_q <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      conv_q <= conv_n;
      sclk_q <= sclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      waking     <= 1'b0;
      cnt        <= '0;
      held       <= '0;
      result     <= '0;
      data_valid <= 1'b0;
    end else if (start_evt) begin
      busy       <= 1'b1;
      data_valid <= 1'b0;
      if (shutdown_mode) begin
        waking <= 1'b1;
        cnt    <= CNT_W'(WAKE_CYCLES - 1);
      end else begin
        waking <= 1'b0;
        held   <= sample_in;
        cnt    <= CNT_W'(CONV_CYCLES - 1);
      end
    end else if (busy) begin
      if (!cnt_last) begin
        cnt <= cnt - 1'b1;
      end else if (waking) begin
        waking <= 1'b0;
        held   <= sample_in;
        cnt    <= CNT_W'(CONV_CYCLES - 1);
      end else begin
        busy       <= 1'b0;
        result     <= held;
        data_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       pos <= '0;
    else if (conv_fall)               pos <= '0;
    else if (sclk_fall && !pos_end)   pos <= pos + 1'b1;
    else if (sclk_rise && pos_end)    pos <= '0;
  end

  assign frame    = {{LEAD_W{1'b0}}, result};
  assign bit_idx  = IDX_W'(FRAME_W - int'(pos));
  assign sdata_oe = (pos != '0);
  assign sdata    = sdata_oe & frame[bit_idx];

  assert_busy_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fall && !busy && !shutdown_mode) |=> (busy && !data_valid && !sdata_oe));

  assert_valid_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> data_valid);

  assert_lead_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && pos <= POS_W'(LEAD_W)) |-> !sdata);

  assert_float_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && pos_end && !conv_fall) |=> !sdata_oe);

  assert_strobe_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_fall |=> !sdata_oe);

  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_last && (conv_fall || conv_rise)) |=> (busy && $stable(held)));

  assert_sleep_no_fall_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_mode && conv_fall && !busy) |=> !busy);
endmodule

// File: tb/serial_adc_port_model_bench.sv
module serial_adc_port_model_bench;
  localparam int SW = 14, FW = 16, CONV = 6, WAKE = 4;

  logic          clk = 1'b0, rst_n = 1'b0, shutdown_mode = 1'b0, conv_n = 1'b1, sclk = 1'b1;
  logic [SW-1:0] sample_in = '0;
  wire           busy, sdata, sdata_oe, data_valid;
  int            n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  serial_adc_port_model #(.SAMPLE_W(SW), .FRAME_W(FW), .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE))
    u_serial_adc_port_model (
      .clk(clk), .rst_n(rst_n), .shutdown_mode(shutdown_mode), .conv_n(conv_n), .sclk(sclk),
      .sample_in(sample_in), .busy(busy), .sdata(sdata), .sdata_oe(sdata_oe),
      .data_valid(data_valid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_word(input int n, output logic [31:0] w, output logic all_oe);
    w = '0;
    all_oe = 1'b1;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      tick();
      w = {w[30:0], sdata};
      all_oe &= sdata_oe;
      sclk = 1'b1;
      tick();
    end
  endtask

  task automatic convert_fast(input logic [SW-1:0] s, output int len);
    sample_in = s;
    conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    sample_in = ~s;
    len = 0;
    while (busy && len < 1000) begin
      len++;
      tick();
    end
  endtask

  task automatic convert_sleep(input logic [SW-1:0] s, output int len, output logic busy_after_fall);
    conv_n = 1'b0;
    tick();
    busy_after_fall = busy;
    conv_n = 1'b1;
    sample_in = ~s;
    len = 0;
    for (int i = 0; i < WAKE; i++) begin
      tick();
      if (busy) len++;
    end
    sample_in = s;
    tick();
    sample_in = ~s ^ 14'h0F0F;
    while (busy && len < 1000) begin
      len++;
      tick();
    end
  endtask

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0]   w;
    logic          oe, bf;
    int            len;
    logic [SW-1:0] pats[18];

    tick(3);
    rst_n = 1'b1;
    tick();
    check("R9 busy", busy, 0);
    check("R9 sdata_oe", sdata_oe, 0);
    check("R9 sdata", sdata, 0);
    check("R9 data_valid", data_valid, 0);

    for (int i = 0; i < SW; i++) pats[i] = SW'(1) << i;
    pats[14] = '0; pats[15] = '1; pats[16] = 14'h2AAA; pats[17] = 14'h1555;

    for (int p = 0; p < 18; p++) begin
      sample_in = pats[p];
      conv_n = 1'b0;
      tick();
      check("R1 busy after fall", busy, 1);
      check("R1 valid cleared", data_valid, 0);
      conv_n = 1'b1;
      sample_in = ~pats[p];
      len = 1;
      tick();
      while (busy && len < 1000) begin
        len++;
        tick();
      end
      check("R2 busy length", len, CONV);
      check("R2 valid after done", data_valid, 1);
      read_word(16, w, oe);
      check("R3 frame", w, {18'd0, pats[p]});
      check("R3 drive during frame", oe, 1);
      check("R4 float after 16", sdata_oe, 0);
    end

    convert_fast(14'h3FFF, len);
    read_word(16, w, oe);
    check("R3 frame all ones", w, 32'h3FFF);
    read_word(4, w, oe);
    check("R5 drift bits", w, 32'h3);
    check("R5 drift drives", oe, 1);
    read_word(12, w, oe);
    check("R5 drift rest", w, 32'hFFF);
    check("R5 back to idle", sdata_oe, 0);

    convert_fast(14'h2C3A, len);
    read_word(5, w, oe);
    check("R6 partial read", w, 32'h5);
    convert_fast(14'h1B65, len);
    check("R6 reset by strobe", sdata_oe, 0);
    read_word(11, w, oe);
    check("R6 crossed read realigned", w, 32'(16'h1B65 >> 5));
    read_word(5, w, oe);
    check("R6 tail", w, 32'h05);

    sample_in = 14'h0ABC;
    conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    sample_in = 14'h3333;
    len = 1;
    tick();
    if (busy) len++;
    conv_n = 1'b0;
    tick();
    if (busy) len++;
    conv_n = 1'b1;
    tick();
    while (busy && len < 1000) begin
      len++;
      tick();
    end
    check("R7 busy not extended", len, CONV);
    read_word(16, w, oe);
    check("R7 first sample kept", w, 32'h0ABC);

    shutdown_mode = 1'b1;
    tick();
    convert_sleep(14'h1234, len, bf);
    check("R8 fall starts nothing", bf, 0);
    check("R8 busy length", len, WAKE + CONV);
    check("R8 valid", data_valid, 1);
    read_word(16, w, oe);
    check("R8 hold-instant sample", w, 32'h1234);
    convert_sleep(14'h3E01, len, bf);
    check("R8 busy length 2", len, WAKE + CONV);
    read_word(16, w, oe);
    check("R8 hold-instant sample 2", w, 32'h3E01);
    shutdown_mode = 1'b0;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule